// File: doc/BRIEF.md
# MII Management Bus Master

This block drives the two-wire MII management bus toward one or more PHYs. The bus has an MDC clock output and a shared MDIO data line, which the block drives through a separate output-enable pin. A requester presents a command on the `req` cycle. The command is a read or write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The master then serialises a complete management frame. That frame is the all-ones preamble, the start and opcode bits, both addresses, the turnaround and the 16 data bits, followed by trailing clocks.

The MDC rate comes from the system clock. `half_period` sets how many system cycles each MDC level lasts, and it is captured when the command is accepted. Every bit slot is one low half-period followed by one high half-period. Data changes only while MDC is low, and inbound data is sampled at the end of the high half. On a read, the master checks that the PHY pulls the turnaround bit to 0. If nothing answers, it clocks a recovery burst with the line released and completes with all-ones data and an error flag. The end of each transaction is a one-cycle `done` pulse.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `mdc` is 0, `mdio_oe` is 0 and `done` is 0; after reset `rdata` is 0x0000 and `err` is 0.
- R2: A frame begins with 32 slots that drive MDIO to 1. Every slot of a frame is H system cycles with `mdc` low and then H cycles with `mdc` high. `mdio_o` and `mdio_oe` never change on the cycle where `mdc` rises.
- R3: Slots 32 and 33 drive 0 then 1. Slots 34 and 35 drive 1,0 for a read (`is_read`=1) and 0,1 for a write.
- R4: Slots 36 to 40 carry `phy_addr` bit 4 down to bit 0. Slots 41 to 45 carry `reg_addr` bit 4 down to bit 0.
- R5: H equals `half_period` captured on the accepting cycle, and a value of 0 is treated as 1.
- R6: A write drives slots 46 and 47 as 1 then 0, and slots 48 to 63 as `wdata` bit 15 down to bit 0. Slot 64 has MDIO released, and `done` follows it. The write completes with `rdata`=0x0000 and `err`=0.
- R7: A read releases MDIO (`mdio_oe`=0) from slot 46 onward. `mdio_i` is sampled on the last system cycle of each high half. The sample at the end of slot 46 must be 0 for the PHY to count as present.
- R8: With the PHY present, the samples of slots 47 to 62 form `rdata` bit 15 down to bit 0. Slots 63 and 64 are two further released MDC cycles, and then `done` completes with `err`=0.
- R9: If the slot-46 sample is 1, slots 47 to 78 are 32 released MDC cycles. The master then completes with `rdata`=0xFFFF and `err`=1.
- R10: A request is taken only while `busy` is low. A `req` raised during a frame has no effect on that frame's MDC/MDIO waveform or result.
- R11: `done` is a single-cycle pulse on the system cycle right after the last high half. `busy` is high from the cycle after acceptance up to that cycle and low on it. `rdata` and `err` change only on the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | HPW | MDC half-period in system cycles (0 acts as 1) |
| req | input | 1 | Command request, taken when idle |
| is_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, held until the next completion |
| err | output | 1 | No PHY answered the read turnaround |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench goes after the turnaround decision, because a master that samples one cycle early or late, or on the wrong level, would judge a present PHY absent or the reverse. When that happens, the frame length jumps from 65 to 79 slots and `rdata` turns into 0xFFFF. Read data is checked with asymmetric patterns, so a swapped bit order or a one-slot shift in the capture window gives a visibly wrong word. A zero half-period and a request injected mid-frame are included as well. A master that did not clamp the divider would hang or wrap. One that restarted on the stray request would break the expected waveform at once.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int HPW      = 8,
  parameter int PREAMBLE = 32,
  parameter int RECOVERY = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HPW-1:0] half_period,
  input  logic           req,
  input  logic           is_read,
  input  logic [4:0]     phy_addr,
  input  logic [4:0]     reg_addr,
  input  logic [15:0]    wdata,
  output logic           busy,
  output logic           done,
  output logic [15:0]    rdata,
  output logic           err,
  output logic           mdc,
  output logic           mdio_o,
  output logic           mdio_oe,
  input  logic           mdio_i
);

  localparam int TA      = PREAMBLE + 14;
  localparam int SLOT_W  = $clog2(TA + RECOVERY + 1);
  localparam logic [SLOT_W-1:0] S_PRE   = SLOT_W'(PREAMBLE);
  localparam logic [SLOT_W-1:0] S_TA    = SLOT_W'(TA);
  localparam logic [SLOT_W-1:0] S_RDLST = SLOT_W'(TA + 16);
  localparam logic [SLOT_W-1:0] S_WEND  = SLOT_W'(TA + 18);
  localparam logic [SLOT_W-1:0] S_REND  = SLOT_W'(TA + RECOVERY);

  logic              run, hi, rd, nophy;
  logic [SLOT_W-1:0] slot, rel, last;
  logic [HPW-1:0]    cnt, hp;
  logic [4:0]        pa, ra;
  logic [15:0]       wd, shreg;
  logic [31:0]       hdr;
  logic              bit_val;

  assign hdr     = {2'b01, rd, ~rd, pa, ra, 2'b10, wd};
  assign rel     = slot - S_PRE;
  assign bit_val = (slot < S_PRE) ? 1'b1 : hdr[5'd31 - rel[4:0]];
  assign last    = nophy ? S_REND : S_WEND;

  assign busy    = run;
  assign mdc     = run & hi;
  assign mdio_oe = run & ((slot < S_TA) | (~rd & (slot < S_WEND)));
  assign mdio_o  = mdio_oe & bit_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      hi    <= 1'b0;
      rd    <= 1'b0;
      nophy <= 1'b0;
      slot  <= '0;
      cnt   <= '0;
      hp    <= HPW'(1);
      pa    <= '0;
      ra    <= '0;
      wd    <= '0;
      shreg <= '0;
      rdata <= '0;
      err   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (req) begin
          run   <= 1'b1;
          hi    <= 1'b0;
          slot  <= '0;
          cnt   <= '0;
          hp    <= (half_period == '0) ? HPW'(1) : half_period;
          rd    <= is_read;
          pa    <= phy_addr;
          ra    <= reg_addr;
          wd    <= wdata;
          nophy <= 1'b0;
        end
      end else if (cnt == hp - HPW'(1)) begin
        cnt <= '0;
        if (!hi) begin
          hi <= 1'b1;
        end else begin
          hi <= 1'b0;
          if (rd && slot == S_TA)
            nophy <= mdio_i;
          if (rd && !nophy && slot > S_TA && slot <= S_RDLST)
            shreg <= {shreg[14:0], mdio_i};
          if (slot == last) begin
            run   <= 1'b0;
            done  <= 1'b1;
            rdata <= !rd ? 16'h0000 : (nophy ? 16'hFFFF : shreg);
            err   <= rd & nophy;
          end else begin
            slot <= slot + SLOT_W'(1);
          end
        end
      end else begin
        cnt <= cnt + HPW'(1);
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r2_data_still_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rdata) && $stable(err)));

  a_r9_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'hFFFF));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rdata(rdata),
  .err(err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_period = 8'd1;
  logic        req = 1'b0;
  logic        is_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .req(req),
    .is_read(is_read), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int s, input logic r, input logic [4:0] p,
                                   input logic [4:0] g, input logic [15:0] w);
    if (s < 32) return 1'b1;
    if (s == 32) return 1'b0;
    if (s == 33) return 1'b1;
    if (s == 34) return r;
    if (s == 35) return ~r;
    if (s <= 40) return p[40 - s];
    if (s <= 45) return g[45 - s];
    if (s == 46) return 1'b1;
    if (s == 47) return 1'b0;
    if (s <= 63) return w[63 - s];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int s, input logic r, input logic present);
    if (s < 32) return "R2";
    if (s < 36) return "R3";
    if (s < 46) return "R4";
    if (!r) return "R6";
    if (s == 46) return "R7";
    return present ? "R8" : "R9";
  endfunction

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1", "idle mdc", {31'b0, mdc}, 32'd0);
      chk("R1", "idle oe", {31'b0, mdio_oe}, 32'd0);
      chk("R1", "idle done", {31'b0, done}, 32'd0);
    end
  endtask

  task automatic txn(input logic r, input logic [4:0] p, input logic [4:0] g,
                     input logic [15:0] w, input logic [7:0] hp_in,
                     input logic present, input logic [15:0] rv,
                     input bit inject, input string hp_tag);
    int h, last, cyc;
    logic [15:0] prev_rd, exp_rd;
    logic prev_err, exp_err;
    h = (hp_in == 0) ? 1 : int'(hp_in);
    last = (r && !present) ? 78 : 64;
    exp_rd  = !r ? 16'h0000 : (present ? rv : 16'hFFFF);
    exp_err = r & ~present;
    @(negedge clk);
    prev_rd = rdata; prev_err = err;
    req = 1'b1; is_read = r; phy_addr = p; reg_addr = g; wdata = w; half_period = hp_in;
    @(negedge clk);
    req = 1'b0;
    is_read = ~r; phy_addr = ~p; reg_addr = ~g; wdata = ~w; half_period = 8'd5;
    cyc = 0;
    for (int s = 0; s <= last; s++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int k = 0; k < h; k++) begin
          string t;
          logic e_oe;
          t = tag_of(s, r, present);
          if (s == 46 && r) mdio_i = present ? 1'b0 : 1'b1;
          else if (r && present && s >= 47 && s <= 62) mdio_i = rv[62 - s];
          else mdio_i = 1'b1;
          e_oe = (s < 46) || (!r && s < 64);
          chk(t, "mdc", {31'b0, mdc}, {31'b0, 1'(ph)});
          chk(hp_tag, "busy", {31'b0, busy}, 32'd1);
          chk(t, "oe", {31'b0, mdio_oe}, {31'b0, e_oe});
          if (e_oe) chk(t, "mdio", {31'b0, mdio_o}, {31'b0, exp_bit(s, r, p, g, w)});
          chk("R11", "no early done", {31'b0, done}, 32'd0);
          chk("R11", "result held", {15'b0, err, rdata}, {15'b0, prev_err, prev_rd});
          if (inject && cyc == 40) req = 1'b1;
          else if (inject && cyc == 41) begin
            req = 1'b0;
            chk("R10", "busy after stray req", {31'b0, busy}, 32'd1);
          end
          cyc++;
          @(negedge clk);
        end
      end
    end
    mdio_i = 1'b1;
    chk("R11", "done pulse", {31'b0, done}, 32'd1);
    chk("R11", "busy low at done", {31'b0, busy}, 32'd0);
    chk(r ? (present ? "R8" : "R9") : "R6", "rdata", {16'b0, rdata}, {16'b0, exp_rd});
    chk(r ? (present ? "R8" : "R9") : "R6", "err", {31'b0, err}, {31'b0, exp_err});
    chk("R1", "mdc low at done", {31'b0, mdc}, 32'd0);
    @(negedge clk);
    chk("R11", "done single", {31'b0, done}, 32'd0);
    chk("R11", "rdata held", {16'b0, rdata}, {16'b0, exp_rd});
    if (inject) chk("R10", "stray req ignored, idle", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rdata", {16'b0, rdata}, 32'd0);
    chk("R1", "reset err", {31'b0, err}, 32'd0);
    chk("R1", "reset busy", {31'b0, busy}, 32'd0);
    rst_n = 1'b1;
    idle_check(3);
    txn(1'b0, 5'h13, 5'h0A, 16'hA5C3, 8'd1, 1'b1, 16'h0000, 1'b0, "R2");
    idle_check(2);
    txn(1'b1, 5'h01, 5'h02, 16'h0000, 8'd2, 1'b1, 16'hB39E, 1'b0, "R5");
    idle_check(2);
    txn(1'b1, 5'h0C, 5'h11, 16'h0000, 8'd1, 1'b0, 16'h0000, 1'b0, "R9");
    idle_check(2);
    txn(1'b0, 5'h1F, 5'h1F, 16'h0001, 8'd0, 1'b1, 16'h0000, 1'b0, "R5");
    idle_check(2);
    txn(1'b1, 5'h06, 5'h19, 16'h0000, 8'd3, 1'b1, 16'h7E81, 1'b1, "R10");
    idle_check(2);
    txn(1'b1, 5'h00, 5'h00, 16'h0000, 8'd1, 1'b1, 16'h5A5A, 1'b0, "R7");
    idle_check(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule